// File: doc/BRIEF.md
# Delayed Branch and Jump Resolver

This block resolves control transfers for a pipeline that executes one delay-slot instruction after every taken branch or jump. On each cycle it looks at the current instruction word, that instruction's PC and the two source register values. From these it decides whether the instruction transfers control, and it forms the destination address. For the linking forms it also requests a write of the return address. For the two single-operand compare forms whose second register field must be zero, it flags a reserved-instruction exception when that field is not zero.

The redirect does not happen at once. When a taken transfer retires (the `step` strobe marks one instruction retiring), the block stores the destination and arms a pending flag. The next retiring instruction is the delay slot. When it retires, the block raises `redirect` with the stored address so that the PC logic outside the block loads it. The PC register, fetch and exception entry stay outside the block.

Top module: `bju_top`

## Requirements
- R1: A conditional transfer's destination is PC+4 plus the sign-extended 16-bit field instr[15:0] shifted left by two.
- R2: An absolute jump (instr[31:26] = 2 plain, 3 linking) keeps bits 31:28 of PC+4 and fills bits 27:0 with instr[25:0] shifted left by two.
- R3: instr[31:26] = 4 is taken when rsVal equals rtVal, and instr[31:26] = 5 is taken when they differ.
- R4: With instr[31:26] = 1, the rt field instr[20:16] selects the test on rsVal as a signed number: 0 and 16 take the branch when rsVal < 0, 1 and 17 when rsVal >= 0. instr[31:26] = 6 takes the branch when rsVal <= 0, and 7 when rsVal > 0.
- R5: When instr[31:26] is 6 or 7 and instr[20:16] is nonzero, `riExc` is 1, `taken` is 0 and no link write is requested.
- R6: The linking forms (instr[31:26] = 3, or 1 with rt field 16 or 17) set `linkWe` with `linkIdx` = 31 and `linkData` = PC+8, but only when the transfer is taken.
- R7: Any other instruction word (for example instr[31:26] = 0, or 1 with rt field 2) gives `taken`, `linkWe` and `riExc` all 0.
- R8: A taken transfer retiring with `step` = 1 does not raise `redirect` in that cycle. The next cycle with `step` = 1 raises `redirect` with `redirectPc` equal to the stored destination. `redirect` is then low in the following cycle.
- R9: A taken transfer that sits in the delay slot does not arm a second redirect.
- R10: After reset, `redirect` is 0 and `redirectPc` is 0.
- R11: While `step` is 0, the pending redirect and its stored destination are held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| step | input | 1 | Current instruction retires this cycle |
| pc | input | 32 | Address of the current instruction |
| instr | input | 32 | Current instruction word |
| rsVal | input | 32 | Value of the first source register |
| rtVal | input | 32 | Value of the second source register |
| taken | output | 1 | Current instruction transfers control |
| target | output | 32 | Destination of the current instruction |
| linkWe | output | 1 | Return-address write request |
| linkIdx | output | 5 | Register index for the return address (31) |
| linkData | output | 32 | Return address, PC+8 |
| riExc | output | 1 | Reserved-instruction exception |
| redirect | output | 1 | Load redirectPc into the PC now |
| redirectPc | output | 32 | Stored destination to load |

## Verification
On every cycle, the assertions check several rules. An exception suppresses both the transfer and the link, and a link is never requested without a taken transfer. Destinations are word aligned, and jumps keep the region bits of PC+4. A redirect only appears on a retiring cycle and never in two cycles running, and the stored destination holds while nothing retires. The exact arithmetic of the destinations, which of the signed tests takes on zero or on negative values, and the delay-slot ordering (no redirect on the branch itself, a redirect on the slot, no re-arm from a branch in the slot) can only be shown by the bench's directed scenarios, which compare against values worked out from the requirements.

// File: rtl/bju_pkg.sv
package bju_pkg;
  // strobes from the decoder to the datapath
  typedef struct packed {
    logic cmpEq;
    logic cmpNe;
    logic sgnLt;
    logic sgnGe;
    logic sgnLe;
    logic sgnGt;
    logic absJump;
    logic doLink;
    logic badRt;
  } bjStrobes_t;

  localparam int unsigned OP_W  = 6;
  localparam int unsigned REG_W = 5;
endpackage

// File: rtl/bju_ctrl.sv
module bju_ctrl
  import bju_pkg::*;
(
  input  logic [OP_W-1:0]  opField,
  input  logic [REG_W-1:0] rtField,
  output bjStrobes_t       st
);
  always_comb begin
    st = '0;
    unique case (opField)
      6'd1: begin
        unique case (rtField)
          5'd0:  st.sgnLt = 1'b1;
          5'd1:  st.sgnGe = 1'b1;
          5'd16: begin st.sgnLt = 1'b1; st.doLink = 1'b1; end
          5'd17: begin st.sgnGe = 1'b1; st.doLink = 1'b1; end
          default: ;
        endcase
      end
      6'd2: st.absJump = 1'b1;
      6'd3: begin st.absJump = 1'b1; st.doLink = 1'b1; end
      6'd4: st.cmpEq = 1'b1;
      6'd5: st.cmpNe = 1'b1;
      6'd6: begin
        if (rtField != '0) st.badRt = 1'b1;
        else               st.sgnLe = 1'b1;
      end
      6'd7: begin
        if (rtField != '0) st.badRt = 1'b1;
        else               st.sgnGt = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bju_datapath.sv
module bju_datapath
  import bju_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IDX_W = 26,
  parameter int unsigned OFF_W = 16
) (
  input  bjStrobes_t       st,
  input  logic [XLEN-1:0]  pc,
  input  logic [IDX_W-1:0] idxField,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [XLEN-1:0]  rtVal,
  output logic             taken,
  output logic [XLEN-1:0]  target,
  output logic             linkWe,
  output logic [XLEN-1:0]  linkData,
  output logic             riExc
);
  localparam int unsigned REGION_W = XLEN - IDX_W - 2;
  localparam int unsigned EXT_W    = XLEN - OFF_W - 2;

  logic [OFF_W-1:0] offField;
  logic [XLEN-1:0]  seqPc;
  logic [XLEN-1:0]  brTarget;
  logic [XLEN-1:0]  jmpTarget;
  logic             isNeg;
  logic             isZero;
  logic             isSame;
  logic             hit;

  assign offField  = idxField[OFF_W-1:0];
  assign seqPc     = pc + XLEN'(4);
  assign brTarget  = seqPc + {{EXT_W{offField[OFF_W-1]}}, offField, 2'b00};
  assign jmpTarget = {seqPc[XLEN-1 -: REGION_W], idxField, 2'b00};

  assign isNeg  = rsVal[XLEN-1];
  assign isZero = (rsVal == '0);
  assign isSame = (rsVal == rtVal);

  always_comb begin
    hit = 1'b0;
    if (st.cmpEq   &&  isSame)             hit = 1'b1;
    if (st.cmpNe   && !isSame)             hit = 1'b1;
    if (st.sgnLt   &&  isNeg)              hit = 1'b1;
    if (st.sgnGe   && !isNeg)              hit = 1'b1;
    if (st.sgnLe   && (isNeg || isZero))   hit = 1'b1;
    if (st.sgnGt   && !isNeg && !isZero)   hit = 1'b1;
    if (st.absJump)                        hit = 1'b1;
  end

  assign taken    = hit;
  assign target   = st.absJump ? jmpTarget : brTarget;
  assign linkWe   = st.doLink && hit;
  assign linkData = pc + XLEN'(8);
  assign riExc    = st.badRt;
endmodule

// File: rtl/bju_delay.sv
module bju_delay #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            step,
  input  logic            armReq,
  input  logic [XLEN-1:0] armTarget,
  output logic            redirect,
  output logic [XLEN-1:0] redirectPc
);
  logic pending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending    <= 1'b0;
      redirectPc <= '0;
    end else if (step) begin
      if (pending) begin
        pending <= 1'b0;
      end else if (armReq) begin
        pending    <= 1'b1;
        redirectPc <= armTarget;
      end
    end
  end

  assign redirect = pending && step;
endmodule

// File: rtl/bju_top.sv
module bju_top
  import bju_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned LINK_REG = 31
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             step,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  instr,
  input  logic [XLEN-1:0]  rsVal,
  input  logic [XLEN-1:0]  rtVal,
  output logic             taken,
  output logic [XLEN-1:0]  target,
  output logic             linkWe,
  output logic [REG_W-1:0] linkIdx,
  output logic [XLEN-1:0]  linkData,
  output logic             riExc,
  output logic             redirect,
  output logic [XLEN-1:0]  redirectPc
);
  localparam int unsigned IDX_W = XLEN - OP_W;

  bjStrobes_t st;

  bju_ctrl u_ctrl (
    .opField (instr[XLEN-1 -: OP_W]),
    .rtField (instr[20:16]),
    .st      (st)
  );

  bju_datapath #(.XLEN(XLEN), .IDX_W(IDX_W), .OFF_W(16)) u_dp (
    .st       (st),
    .pc       (pc),
    .idxField (instr[IDX_W-1:0]),
    .rsVal    (rsVal),
    .rtVal    (rtVal),
    .taken    (taken),
    .target   (target),
    .linkWe   (linkWe),
    .linkData (linkData),
    .riExc    (riExc)
  );

  bju_delay #(.XLEN(XLEN)) u_delay (
    .clk        (clk),
    .rstN       (rstN),
    .step       (step),
    .armReq     (taken),
    .armTarget  (target),
    .redirect   (redirect),
    .redirectPc (redirectPc)
  );

  assign linkIdx = REG_W'(LINK_REG);
endmodule

// File: rtl/bju_checker.sv
module bju_checker #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            step,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr,
  input logic            taken,
  input logic [XLEN-1:0] target,
  input logic            linkWe,
  input logic            riExc,
  input logic            redirect,
  input logic [XLEN-1:0] redirectPc
);
  logic [XLEN-1:0] pcNext;
  assign pcNext = pc + XLEN'(4);

  a_r5_ri_blocks: assert property (@(posedge clk) disable iff (!rstN)
    riExc |-> (!taken && !linkWe));

  a_r6_link_only_taken: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |-> taken);

  a_r1_aligned_target: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> (target[1:0] == 2'b00));

  a_r2_region_kept: assert property (@(posedge clk) disable iff (!rstN)
    (taken && instr[XLEN-1 -: 5] == 5'b00001) |-> (target[XLEN-1 -: 4] == pcNext[XLEN-1 -: 4]));

  a_r8_redirect_on_step: assert property (@(posedge clk) disable iff (!rstN)
    redirect |-> step);

  a_r8_single_redirect: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !redirect);

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !step |=> $stable(redirectPc));
endmodule

bind bju_top bju_checker #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_bju_top.sv
module tb_bju_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        step;
  logic [31:0] pc, instr, rsVal, rtVal;
  logic        taken, linkWe, riExc, redirect;
  logic [31:0] target, linkData, redirectPc;
  logic [4:0]  linkIdx;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bju_top dut (
    .clk(clk), .rstN(rstN), .step(step), .pc(pc), .instr(instr),
    .rsVal(rsVal), .rtVal(rtVal), .taken(taken), .target(target),
    .linkWe(linkWe), .linkIdx(linkIdx), .linkData(linkData), .riExc(riExc),
    .redirect(redirect), .redirectPc(redirectPc)
  );

  function automatic logic [31:0] encI(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] encJ(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction

  function automatic logic [31:0] expBr(input logic [31:0] p, input logic [15:0] imm);
    logic [31:0] off;
    off = {{14{imm[15]}}, imm, 2'b00};
    return p + 32'd4 + off;
  endfunction

  function automatic logic [31:0] expJmp(input logic [31:0] p, input logic [25:0] idx);
    logic [31:0] s;
    s = p + 32'd4;
    return {s[31:28], idx, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one instruction after a falling edge; outputs sampled 1 ns later
  task automatic drive(input logic [31:0] p, input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, input logic s);
    @(negedge clk);
    pc = p; instr = w; rsVal = a; rtVal = b; step = s;
    #1;
  endtask

  task automatic t_reset;
    chk("R10 redirect", {31'd0, redirect}, 32'd0);
    chk("R10 redirectPc", redirectPc, 32'd0);
  endtask

  task automatic t_equality;
    drive(32'h0000_1000, encI(6'd4, 5'd1, 5'd2, 16'h0010), 32'd7, 32'd7, 1'b0);
    chk("R3 eq taken", {31'd0, taken}, 32'd1);
    chk("R1 eq target", target, expBr(32'h0000_1000, 16'h0010));
    drive(32'h0000_1000, encI(6'd4, 5'd1, 5'd2, 16'h0010), 32'd7, 32'd8, 1'b0);
    chk("R3 eq not taken", {31'd0, taken}, 32'd0);
    drive(32'h0000_2000, encI(6'd5, 5'd1, 5'd2, 16'hFFFC), 32'd7, 32'd8, 1'b0);
    chk("R3 ne taken", {31'd0, taken}, 32'd1);
    chk("R1 negative offset", target, expBr(32'h0000_2000, 16'hFFFC));
    drive(32'h0000_2000, encI(6'd5, 5'd1, 5'd2, 16'hFFFC), 32'd9, 32'd9, 1'b0);
    chk("R3 ne not taken", {31'd0, taken}, 32'd0);
  endtask

  task automatic t_signed;
    drive(32'h100, encI(6'd1, 5'd3, 5'd0, 16'h4), 32'hFFFF_FFFF, 0, 1'b0);
    chk("R4 lt neg", {31'd0, taken}, 32'd1);
    drive(32'h100, encI(6'd1, 5'd3, 5'd0, 16'h4), 32'd0, 0, 1'b0);
    chk("R4 lt zero", {31'd0, taken}, 32'd0);
    drive(32'h100, encI(6'd1, 5'd3, 5'd1, 16'h4), 32'd0, 0, 1'b0);
    chk("R4 ge zero", {31'd0, taken}, 32'd1);
    drive(32'h100, encI(6'd1, 5'd3, 5'd1, 16'h4), 32'h8000_0000, 0, 1'b0);
    chk("R4 ge neg", {31'd0, taken}, 32'd0);
    drive(32'h100, encI(6'd6, 5'd3, 5'd0, 16'h4), 32'd0, 0, 1'b0);
    chk("R4 le zero", {31'd0, taken}, 32'd1);
    drive(32'h100, encI(6'd6, 5'd3, 5'd0, 16'h4), 32'd5, 0, 1'b0);
    chk("R4 le pos", {31'd0, taken}, 32'd0);
    drive(32'h100, encI(6'd7, 5'd3, 5'd0, 16'h4), 32'h7FFF_FFFF, 0, 1'b0);
    chk("R4 gt pos", {31'd0, taken}, 32'd1);
    drive(32'h100, encI(6'd7, 5'd3, 5'd0, 16'h4), 32'd0, 0, 1'b0);
    chk("R4 gt zero", {31'd0, taken}, 32'd0);
  endtask

  task automatic t_reserved;
    drive(32'h200, encI(6'd6, 5'd3, 5'd3, 16'h4), 32'd0, 0, 1'b0);
    chk("R5 le ri", {30'd0, riExc, taken}, 32'd2);
    drive(32'h200, encI(6'd7, 5'd3, 5'd1, 16'h4), 32'd5, 0, 1'b0);
    chk("R5 gt ri", {29'd0, riExc, taken, linkWe}, 32'd4);
  endtask

  task automatic t_link;
    drive(32'h0000_3000, encI(6'd1, 5'd3, 5'd16, 16'h8), 32'hFFFF_FFF0, 0, 1'b0);
    chk("R6 lt-link we", {31'd0, linkWe}, 32'd1);
    chk("R6 link idx", {27'd0, linkIdx}, 32'd31);
    chk("R6 link data", linkData, 32'h0000_3008);
    drive(32'h0000_3000, encI(6'd1, 5'd3, 5'd16, 16'h8), 32'd1, 0, 1'b0);
    chk("R6 lt-link not taken", {31'd0, linkWe}, 32'd0);
    drive(32'h0000_3000, encI(6'd1, 5'd3, 5'd17, 16'h8), 32'd1, 0, 1'b0);
    chk("R6 ge-link we", {31'd0, linkWe}, 32'd1);
    drive(32'hA000_0040, encJ(6'd3, 26'h123_4567), 0, 0, 1'b0);
    chk("R6 jump-link data", linkData, 32'hA000_0048);
    chk("R6 jump-link we", {31'd0, linkWe}, 32'd1);
  endtask

  task automatic t_jump;
    drive(32'hA000_0040, encJ(6'd2, 26'h3FF_FFFF), 0, 0, 1'b0);
    chk("R2 jump taken", {31'd0, taken}, 32'd1);
    chk("R2 jump target", target, expJmp(32'hA000_0040, 26'h3FF_FFFF));
    chk("R2 jump no link", {31'd0, linkWe}, 32'd0);
    drive(32'h3FFF_FFFC, encJ(6'd2, 26'h000_0010), 0, 0, 1'b0);
    chk("R2 region from PC+4", target, 32'h4000_0040);
  endtask

  task automatic t_other;
    drive(32'h400, {6'd0, 5'd1, 5'd2, 5'd3, 11'h21}, 32'd1, 32'd1, 1'b0);
    chk("R7 alu word", {29'd0, taken, linkWe, riExc}, 32'd0);
    drive(32'h400, encI(6'd1, 5'd1, 5'd2, 16'h4), 32'hFFFF_FFFF, 0, 1'b0);
    chk("R7 unknown rt code", {29'd0, taken, linkWe, riExc}, 32'd0);
  endtask

  task automatic t_delay;
    logic [31:0] exp;
    exp = expBr(32'h0000_5000, 16'h0020);
    drive(32'h0000_5000, encI(6'd4, 5'd1, 5'd1, 16'h0020), 32'd3, 32'd3, 1'b1);
    chk("R8 no redirect on branch", {31'd0, redirect}, 32'd0);
    drive(32'h0000_5004, 32'd0, 0, 0, 1'b1);
    chk("R8 redirect on slot", {31'd0, redirect}, 32'd1);
    chk("R8 redirect target", redirectPc, exp);
    drive(exp, 32'd0, 0, 0, 1'b1);
    chk("R8 redirect drops", {31'd0, redirect}, 32'd0);
  endtask

  task automatic t_hold;
    drive(32'hA000_0000, encJ(6'd2, 26'h000_0100), 0, 0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      drive(32'h0, encJ(6'd2, 26'h3AA_AAAA), 0, 0, 1'b0);
      chk("R11 idle no redirect", {31'd0, redirect}, 32'd0);
    end
    drive(32'hA000_0004, 32'd0, 0, 0, 1'b1);
    chk("R11 held redirect", {31'd0, redirect}, 32'd1);
    chk("R11 held target", redirectPc, 32'hA000_0400);
  endtask

  task automatic t_slot_branch;
    drive(32'h0000_6000, encI(6'd5, 5'd1, 5'd2, 16'h0040), 32'd1, 32'd2, 1'b1);
    drive(32'h0000_6004, encI(6'd5, 5'd1, 5'd2, 16'h0080), 32'd1, 32'd2, 1'b1);
    chk("R9 first target used", redirectPc, expBr(32'h0000_6000, 16'h0040));
    chk("R9 redirect on slot", {31'd0, redirect}, 32'd1);
    drive(32'h0000_6104, 32'd0, 0, 0, 1'b1);
    chk("R9 no second redirect", {31'd0, redirect}, 32'd0);
  endtask

  initial begin
    rstN = 1'b0; step = 1'b0; pc = '0; instr = '0; rsVal = '0; rtVal = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    t_reset();
    t_equality();
    t_signed();
    t_reserved();
    t_link();
    t_jump();
    t_other();
    t_delay();
    t_hold();
    t_slot_branch();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nRun++;
        nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule